// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block sits in the bus interface of a 32-bit processor. It services a maskable interrupt request. When the request input is high and interrupts are enabled, it places two acknowledge cycles on the external bus, one after the other. Each cycle behaves like a read. The cycle opens with a one-clock address strobe and then waits for the active-low ready input. The address, the active-low byte enables and three bus-definition lines tell the two cycles apart.

After each cycle the bus is parked in an idle encoding for a parameterised number of clocks. The 8-bit interrupt vector is taken from the low byte lane when the second cycle completes. The vector is then held for the core on a valid/ready handshake. While the vector is waiting, or while a sequence is in progress, no further request is taken.

Top module: `intack_seq`

## Requirements
- R1: A sequence starts only at a clock edge where the block is idle, `irq_req` and `int_en` are both 1 and no vector is pending. The strobe then goes low in the next clock.
- R2: Every accepted request produces exactly two acknowledge cycles. The second cycle's strobe follows the first cycle's idle gap with no other clock in between.
- R3: During the whole first cycle `addr_o` is 4 (only bit 2 set) and `be_n` is 4'b1110 (only lane 0 enabled). `mio_o`, `dc_o` and `wr_o` are all 0.
- R4: `strobe_n` is low for exactly one clock at the start of each cycle. The cycle ends at the first later clock edge where `rdy_n` is sampled 0. A low `rdy_n` during the strobe clock is ignored.
- R5: During the whole second cycle `addr_o` is 0 and `be_n` is 4'b1110. `mio_o`, `dc_o` and `wr_o` are all 0.
- R6: `vec_o` takes `data_i[7:0]` as sampled at the edge that ends the second cycle. `vec_valid` rises in the next clock. Data on the bus during the first cycle has no effect on `vec_o`.
- R7: After each cycle the bus is idle for IDLE_CLKS clocks (default 2). When no cycle is running, the outputs are `strobe_n`=1, `addr_o`=0, `be_n`=4'b1111 and `mio_o`=`dc_o`=`wr_o`=1.
- R8: Once set, `vec_valid` and `vec_o` stay unchanged until a clock edge with `vec_ready`=1. `vec_valid` is 0 after that edge.
- R9: While `vec_valid` is 1, or while a sequence is running, `irq_req` has no effect on the bus outputs.
- R10: Synchronous active-high `rst` puts the block into idle, even in the middle of a sequence. After the reset edge `strobe_n`=1, `be_n`=4'b1111 and `vec_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request |
| int_en | input | 1 | Interrupt-enable flag from the core |
| rdy_n | input | 1 | Active-low bus ready |
| data_i | input | 32 | Bus read data |
| strobe_n | output | 1 | Active-low address strobe |
| addr_o | output | 32 | Byte address |
| be_n | output | 4 | Active-low byte enables |
| mio_o | output | 1 | Memory/IO definition line |
| dc_o | output | 1 | Data/control definition line |
| wr_o | output | 1 | Write/read definition line |
| vec_o | output | 8 | Captured interrupt vector |
| vec_valid | output | 1 | Vector available to the core |
| vec_ready | input | 1 | Core accepts the vector |

## Verification
The hardest state to reach is a new request arriving while the previous vector is still unaccepted. At that point the sequence has already ended, so only the gating on the pending vector keeps the bus quiet. The stimulus holds `irq_req` high and keeps `vec_ready` low for long stretches, then releases it at random points, some of them during the trailing idle gap. Randomised ready timing, including a low `rdy_n` during the strobe clock, covers the ready wait. A reset in the middle of a sequence covers the return to idle.

// File: rtl/intack_pkg.sv
package intack_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_C1_ADS,
      ST_C1_WAIT,
      ST_GAP1,
      ST_C2_ADS,
      ST_C2_WAIT,
      ST_GAP2
   } iack_state_e;

   typedef struct packed {
      logic ads;
      logic in_cyc;
      logic sec_cyc;
   } bus_phase_t;

endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
   import intack_pkg::*;
#(
   parameter int IDLE_CLKS = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       irq_req,
   input  logic       int_en,
   input  logic       rdy_n,
   input  logic       pending,
   output bus_phase_t phase,
   output logic       capture
);

   localparam int CW = (IDLE_CLKS < 2) ? 1 : $clog2(IDLE_CLKS);
   localparam logic [CW-1:0] GAP_LOAD = CW'(IDLE_CLKS - 1);

   generate
      if (IDLE_CLKS < 1) begin : g_bad_gap
         $error("intack_ctrl: IDLE_CLKS must be at least 1");
      end
   endgenerate

   iack_state_e st, st_nx;
   logic [CW-1:0] gap_cnt;
   logic          gap_done;

   assign gap_done = (gap_cnt == '0);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:    if (irq_req && int_en && !pending) st_nx = ST_C1_ADS;
         ST_C1_ADS:  st_nx = ST_C1_WAIT;
         ST_C1_WAIT: if (!rdy_n) st_nx = ST_GAP1;
         ST_GAP1:    if (gap_done) st_nx = ST_C2_ADS;
         ST_C2_ADS:  st_nx = ST_C2_WAIT;
         ST_C2_WAIT: if (!rdy_n) st_nx = ST_GAP2;
         ST_GAP2:    if (gap_done) st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         gap_cnt <= '0;
      end else begin
         st <= st_nx;
         if ((st == ST_C1_WAIT || st == ST_C2_WAIT) && !rdy_n)
            gap_cnt <= GAP_LOAD;
         else if ((st == ST_GAP1 || st == ST_GAP2) && !gap_done)
            gap_cnt <= gap_cnt - 1'b1;
      end
   end

   always_comb begin
      phase.ads     = (st == ST_C1_ADS) || (st == ST_C2_ADS);
      phase.in_cyc  = (st == ST_C1_ADS) || (st == ST_C1_WAIT) ||
                      (st == ST_C2_ADS) || (st == ST_C2_WAIT);
      phase.sec_cyc = (st == ST_C2_ADS) || (st == ST_C2_WAIT);
   end

   assign capture = (st == ST_C2_WAIT) && !rdy_n;

   // R1: leaving idle needs an enabled request and no pending vector
   a_r1_start_gate: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE && !(irq_req && int_en && !pending)) |=> (st == ST_IDLE));
   // R2: the first gap can only lead into the second cycle
   a_r2_gap_to_second: assert property (@(posedge clk) disable iff (rst)
      (st == ST_GAP1) |=> (st == ST_GAP1 || st == ST_C2_ADS));
   // R4: ready during the strobe clock is ignored
   a_r4_ads_ignores_ready: assert property (@(posedge clk) disable iff (rst)
      (st == ST_C1_ADS) |=> (st == ST_C1_WAIT));
   // R4: a cycle waits while ready is inactive
   a_r4_wait_holds: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_C2_WAIT || st == ST_C1_WAIT) && rdy_n) |=> $stable(st));
   // R9: a pending vector blocks any start
   a_r9_pending_blocks: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE && pending) |=> (st == ST_IDLE));
   // R10: reset returns to idle
   a_r10_reset_idle: assert property (@(posedge clk)
      rst |=> (st == ST_IDLE));

endmodule

// File: rtl/intack_bus_drive.sv
module intack_bus_drive
   import intack_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LANES    = 4,
   parameter int VEC_LANE = 0
) (
   input  bus_phase_t         phase,
   output logic               strobe_n,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [LANES-1:0]   be_n,
   output logic               mio_o,
   output logic               dc_o,
   output logic               wr_o
);

   localparam int SEL_BIT = 2;

   generate
      if (ADDR_W <= SEL_BIT) begin : g_bad_addr
         $error("intack_bus_drive: ADDR_W too small for the cycle select bit");
      end
      if (VEC_LANE >= LANES) begin : g_bad_lane
         $error("intack_bus_drive: VEC_LANE outside the bus");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < ADDR_W; b++) begin : g_addr
         if (b == SEL_BIT) begin : g_sel
            assign addr_o[b] = phase.in_cyc && !phase.sec_cyc;
         end else begin : g_zero
            assign addr_o[b] = 1'b0;
         end
      end
      for (b = 0; b < LANES; b++) begin : g_lane
         if (b == VEC_LANE) begin : g_on
            assign be_n[b] = !phase.in_cyc;
         end else begin : g_off
            assign be_n[b] = 1'b1;
         end
      end
   endgenerate

   assign strobe_n = !phase.ads;
   assign mio_o    = !phase.in_cyc;
   assign dc_o     = !phase.in_cyc;
   assign wr_o     = !phase.in_cyc;

endmodule

// File: rtl/intack_vec_hold.sv
module intack_vec_hold #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic [VEC_W-1:0] lane_data,
   input  logic             vec_ready,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_valid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         vec_o     <= '0;
         vec_valid <= 1'b0;
      end else if (capture) begin
         vec_o     <= lane_data;
         vec_valid <= 1'b1;
      end else if (vec_valid && vec_ready) begin
         vec_valid <= 1'b0;
      end
   end

   // R6: the captured value is the lane seen at the ending edge
   a_r6_capture_lane: assert property (@(posedge clk) disable iff (rst)
      capture |=> (vec_valid && vec_o == $past(lane_data)));
   // R8: vector held until taken
   a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
      (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_o)));
   // R8: acceptance clears valid
   a_r8_clear_on_take: assert property (@(posedge clk) disable iff (rst)
      (vec_valid && vec_ready) |=> !vec_valid);

endmodule

// File: rtl/intack_seq.sv
module intack_seq
   import intack_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int VEC_W     = 8,
   parameter int VEC_LANE  = 0,
   parameter int IDLE_CLKS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              irq_req,
   input  logic              int_en,
   input  logic              rdy_n,
   input  logic [DATA_W-1:0] data_i,
   output logic              strobe_n,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W/8-1:0] be_n,
   output logic              mio_o,
   output logic              dc_o,
   output logic              wr_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_valid,
   input  logic              vec_ready
);

   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("intack_seq: DATA_W must be a whole number of bytes");
      end
      if (VEC_W > 8) begin : g_bad_vec
         $error("intack_seq: VEC_W must fit one byte lane");
      end
   endgenerate

   bus_phase_t phase;
   logic       capture;
   logic       unused_data;

   assign unused_data = ^data_i;

   intack_ctrl #(.IDLE_CLKS(IDLE_CLKS)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .irq_req (irq_req),
      .int_en  (int_en),
      .rdy_n   (rdy_n),
      .pending (vec_valid),
      .phase   (phase),
      .capture (capture)
   );

   intack_bus_drive #(
      .ADDR_W   (ADDR_W),
      .LANES    (LANES),
      .VEC_LANE (VEC_LANE)
   ) u_drive (
      .phase    (phase),
      .strobe_n (strobe_n),
      .addr_o   (addr_o),
      .be_n     (be_n),
      .mio_o    (mio_o),
      .dc_o     (dc_o),
      .wr_o     (wr_o)
   );

   intack_vec_hold #(.VEC_W(VEC_W)) u_vec (
      .clk       (clk),
      .rst       (rst),
      .capture   (capture),
      .lane_data (data_i[VEC_LANE*8 +: VEC_W]),
      .vec_ready (vec_ready),
      .vec_o     (vec_o),
      .vec_valid (vec_valid)
   );

   // R4: strobe lasts a single clock
   a_r4_strobe_one_clock: assert property (@(posedge clk) disable iff (rst)
      !strobe_n |=> strobe_n);
   // R3: a strobe with select bit set shows only the vector lane and the ack code
   a_r3_first_encoding: assert property (@(posedge clk) disable iff (rst)
      (!strobe_n && addr_o[2]) |-> ($countones(~be_n) == 1 && !be_n[VEC_LANE]
                                    && !mio_o && !dc_o && !wr_o));
   // R7: outside a cycle no lane is enabled
   a_r7_idle_no_lane: assert property (@(posedge clk) disable iff (rst)
      (mio_o && dc_o && wr_o) |-> (be_n == '1 && strobe_n && addr_o == '0));
   // R10: reset leaves the strobe off and nothing pending
   a_r10_reset_outputs: assert property (@(posedge clk)
      rst |=> (strobe_n && be_n == '1 && !vec_valid));

endmodule

// File: tb/test_intack_seq.sv
module test_intack_seq;

   localparam int G = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        irq_req = 1'b0;
   logic        int_en = 1'b0;
   logic        rdy_n = 1'b1;
   logic [31:0] data_i = '0;
   logic        vec_ready = 1'b0;
   logic        strobe_n;
   logic [31:0] addr_o;
   logic [3:0]  be_n;
   logic        mio_o, dc_o, wr_o;
   logic [7:0]  vec_o;
   logic        vec_valid;

   intack_seq #(.IDLE_CLKS(G)) i_intack_seq (
      .clk(clk), .rst(rst), .irq_req(irq_req), .int_en(int_en),
      .rdy_n(rdy_n), .data_i(data_i), .strobe_n(strobe_n), .addr_o(addr_o),
      .be_n(be_n), .mio_o(mio_o), .dc_o(dc_o), .wr_o(wr_o),
      .vec_o(vec_o), .vec_valid(vec_valid), .vec_ready(vec_ready)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int rdy_mode = 0;   // 0 always ready, 1 random
   int vr_mode  = 0;   // 0 always take, 1 never, 2 random
   bit started = 0;

   // reference model: which acknowledge cycle, strobe clock, gap left
   int  m_cyc  = 0;    // 0 none, 1 or 2 active cycle
   bit  m_ads  = 0;
   int  m_gap  = 0;    // idle clocks still to run
   int  m_next = 0;    // cycle that follows the gap (0 = sequence done)
   bit  m_valid = 0;
   logic [7:0] m_vec = '0;
   bit  m_rst_seen = 0;

   always @(posedge clk) begin
      bit old_valid;
      started = 1;
      old_valid = m_valid;
      m_rst_seen = rst;
      if (rst) begin
         m_cyc = 0; m_ads = 0; m_gap = 0; m_next = 0; m_valid = 0; m_vec = '0;
      end else begin
         if (old_valid && vec_ready) m_valid = 0;
         if (m_cyc != 0) begin
            if (m_ads) m_ads = 0;
            else if (!rdy_n) begin
               if (m_cyc == 2) begin
                  m_vec = data_i[7:0];
                  m_valid = 1;
               end
               m_next = (m_cyc == 1) ? 2 : 0;
               m_cyc = 0;
               m_gap = G;
            end
         end else if (m_gap > 0) begin
            m_gap--;
            if (m_gap == 0 && m_next == 2) begin
               m_cyc = 2; m_ads = 1; m_next = 0;
            end
         end else if (irq_req && int_en && !old_valid) begin
            m_cyc = 1; m_ads = 1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         string rt;
         rt = m_rst_seen ? " R10" : "";
         check({"R1 R2 R4 strobe", rt}, 32'(strobe_n), 32'(!m_ads));
         check({"R3 R5 addr", rt}, addr_o, (m_cyc == 1) ? 32'd4 : 32'd0);
         check({"R3 R5 R7 be_n", rt}, 32'(be_n), (m_cyc != 0) ? 32'he : 32'hf);
         check({"R3 R7 definition", rt}, 32'({mio_o, dc_o, wr_o}),
               (m_cyc != 0) ? 32'd0 : 32'd7);
         check({"R8 R9 valid", rt}, 32'(vec_valid), 32'(m_valid));
         if (m_valid) check("R6 vector", 32'(vec_o), 32'(m_vec));
      end
   end

   always @(posedge clk) begin
      #5;
      data_i = $urandom;
      if (rdy_mode == 0) rdy_n = 1'b0;
      else rdy_n = ($urandom_range(0, 3) == 0);
      case (vr_mode)
         0: vec_ready = 1'b1;
         1: vec_ready = 1'b0;
         default: vec_ready = ($urandom_range(0, 3) == 0);
      endcase
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
   end

   initial begin
      step(3);
      rst = 1'b0;
      // R1: request with interrupts disabled does nothing
      irq_req = 1'b1; int_en = 1'b0; vr_mode = 0;
      step(30);
      // R2 R3 R5: back-to-back sequences with immediate ready (ready in strobe clock ignored, R4)
      int_en = 1'b1; rdy_mode = 0;
      step(60);
      // R4 R6: random ready waits
      rdy_mode = 1;
      step(300);
      // R9: pending vector blocks further requests
      vr_mode = 1;
      step(80);
      vr_mode = 2;
      step(300);
      // R1: single request pulses
      for (int k = 0; k < 20; k++) begin
         irq_req = 1'b1; step(1);
         irq_req = 1'b0; step($urandom_range(10, 30));
      end
      // R10: reset in the middle of a sequence
      irq_req = 1'b1; rdy_mode = 1; vr_mode = 0;
      for (int k = 0; k < 10; k++) begin
         step($urandom_range(3, 15));
         rst = 1'b1; step(2);
         rst = 1'b0;
      end
      // enable toggling with random handshakes
      vr_mode = 2;
      for (int k = 0; k < 300; k++) begin
         int_en = $urandom_range(0, 1);
         irq_req = $urandom_range(0, 1);
         step(1);
      end
      irq_req = 1'b0;
      step(20);
      finish_up();
   end

endmodule